// File: doc/BRIEF.md
# I2C Bus Recovery Pulse Sequencer

This block frees an I2C bus when a slave device is stuck holding SDA low, typically because it lost count of clock edges and is still waiting to drive an acknowledge bit. A single request starts a fixed train of nine recovery iterations. Each iteration is a short start-like condition followed by a release. In the start-like part, SDA is pulled low first and SCL follows one microsecond later. In the release part, SCL is let go first and SDA one microsecond later. Every iteration therefore gives the stuck slave one full SCL low/high cycle.

Phase lengths are counted in whole microseconds, using a one-cycle-wide tick enable. The caller supplies a delay unit, normally the bus period in microseconds plus one. The asserted part lasts one unit and the released part lasts two units. Unit values below 2 are raised to 2. The unit is captured when the sequence starts. The block drives open-drain enables, where 1 means pull the line low. It holds busy for the whole train and gives a one-cycle done pulse when the train ends, with both lines released.

Top module: `recov_seq`

## Requirements
- R1: While reset is applied and in the first cycle after reset, scl_oe, sda_oe, busy and done are all 0.
- R2: A request sampled while idle starts a sequence, and busy is 1 from the following cycle until the sequence ends.
- R3: A sequence consists of exactly 9 iterations, each of 3 delay units. Busy falls, and done rises, in the cycle after the clock edge that samples the 27·D-th tick since the start, where D is the effective delay unit.
- R4: In the asserted part of an iteration (its first D ticks), sda_oe is 1 throughout, and scl_oe is 1 from the second tick of that part onward.
- R5: In the released part of an iteration (the next 2·D ticks), scl_oe is 0, and sda_oe is 1 only during the first tick of that part.
- R6: The effective delay unit is the larger of delay_us and 2, so the values 0 and 1 behave as 2.
- R7: delay_us is sampled only at the start of a sequence. Changing it during a sequence has no effect on that sequence.
- R8: A request that arrives while busy is 1 is ignored and does not restart or lengthen the sequence.
- R9: Done is a single-cycle pulse. Whenever busy is 0, both scl_oe and sda_oe are 0.
- R10: The sequence advances only in cycles where tick_us is 1. Without ticks, the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start a recovery sequence (sampled when idle) |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| delay_us | input | DLY_W | Delay unit in microseconds (floored to MIN_DLY) |
| scl_oe | output | 1 | 1 = pull SCL low |
| sda_oe | output | 1 | 1 = pull SDA low |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The bench builds the block with its default parameters: a 16-bit delay unit, nine iterations and a floor of 2. It drives delay units from 0 to 4, so that a complete train of 27·D ticks fits in a few hundred cycles, and both values below the floor are applied. It varies the tick spacing, including a tick on every cycle and a long gap with no ticks in the middle of a train. It also sends extra requests and delay changes during a train, so that the latching and ignore rules are exercised against a tick-position reference model.

// File: rtl/recov_pkg.sv
package recov_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DRIVE = 2'd1,
    PH_FREE  = 2'd2
  } phase_e;

  // Effective delay unit: never below the floor
  function automatic int unsigned floor_delay(int unsigned d, int unsigned mn);
    return (d < mn) ? mn : d;
  endfunction

  // Ticks in a phase: driven part is one unit, free part is two
  function automatic int unsigned phase_len(int unsigned d, logic free_part);
    return free_part ? (2 * d) : d;
  endfunction

endpackage

// File: rtl/recov_timer.sv
module recov_timer #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             expire
);

  assign expire = en && tick && (count == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               count <= '0;
    else if (clr)             count <= '0;
    else if (en && tick)      count <= expire ? '0 : count + CNT_W'(1);
  end

endmodule

// File: rtl/recov_ctrl.sv
module recov_ctrl
  import recov_pkg::*;
#(
  parameter int DLY_W   = 16,
  parameter int PULSES  = 9,
  parameter int MIN_DLY = 2,
  localparam int IW = (PULSES > 1) ? $clog2(PULSES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [DLY_W-1:0] delay_us,
  input  logic             expire,
  output phase_e           phase,
  output logic [DLY_W-1:0] dly_q,
  output logic [IW-1:0]    iter_idx,
  output logic             start,
  output logic             done
);

  logic last_iter;

  assign start     = (phase == PH_IDLE) && req;
  assign last_iter = (iter_idx == IW'(PULSES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      dly_q    <= '0;
      iter_idx <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (req) begin
          phase    <= PH_DRIVE;
          dly_q    <= DLY_W'(floor_delay(32'(delay_us), MIN_DLY));
          iter_idx <= '0;
        end
        PH_DRIVE: if (expire) phase <= PH_FREE;
        PH_FREE: if (expire) begin
          if (last_iter) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else begin
            iter_idx <= iter_idx + IW'(1);
            phase    <= PH_DRIVE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/recov_drive.sv
module recov_drive
  import recov_pkg::*;
#(
  parameter int CNT_W = 17
) (
  input  phase_e           phase,
  input  logic [CNT_W-1:0] count,
  output logic             scl_oe,
  output logic             sda_oe
);

  logic first_tick;
  assign first_tick = (count == '0);

  // Start-like: SDA falls, SCL follows one tick later.
  // Stop-like: SCL rises, SDA follows one tick later.
  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    unique case (phase)
      PH_DRIVE: begin
        sda_oe = 1'b1;
        scl_oe = !first_tick;
      end
      PH_FREE:  sda_oe = first_tick;
      default: ;
    endcase
  end

endmodule

// File: rtl/recov_seq.sv
module recov_seq
  import recov_pkg::*;
#(
  parameter int DLY_W   = 16,
  parameter int PULSES  = 9,
  parameter int MIN_DLY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             tick_us,
  input  logic [DLY_W-1:0] delay_us,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             busy,
  output logic             done
);

  localparam int CNT_W = DLY_W + 1;
  localparam int IW    = (PULSES > 1) ? $clog2(PULSES) : 1;

  phase_e           phase;
  logic [DLY_W-1:0] dly_q;
  logic [IW-1:0]    iter_idx;
  logic             start;
  logic             expire;
  logic [CNT_W-1:0] tcount;
  logic [CNT_W-1:0] limit;

  assign busy  = (phase != PH_IDLE);
  assign limit = CNT_W'(phase_len(32'(dly_q), phase == PH_FREE));

  recov_ctrl #(
    .DLY_W(DLY_W), .PULSES(PULSES), .MIN_DLY(MIN_DLY)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .delay_us(delay_us),
    .expire(expire), .phase(phase), .dly_q(dly_q),
    .iter_idx(iter_idx), .start(start), .done(done)
  );

  recov_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(start), .en(busy),
    .tick(tick_us), .limit(limit), .count(tcount), .expire(expire)
  );

  recov_drive #(.CNT_W(CNT_W)) u_drive (
    .phase(phase), .count(tcount), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

endmodule

// File: rtl/recov_seq_chk.sv
module recov_seq_chk #(
  parameter int DLY_W   = 16,
  parameter int PULSES  = 9,
  parameter int MIN_DLY = 2,
  localparam int IW = (PULSES > 1) ? $clog2(PULSES) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_us,
  input logic             busy,
  input logic             done,
  input logic             sda_oe,
  input logic             scl_oe,
  input logic [IW-1:0]    iter_idx,
  input logic [DLY_W-1:0] dly_q
);

  assert_idle_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sda_oe && !scl_oe));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ends_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_hold_without_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick_us) |=> (busy && $stable(sda_oe) && $stable(scl_oe)));

  assert_scl_within_sda_R4: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> sda_oe);

  assert_iter_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (iter_idx <= IW'(PULSES - 1)));

  assert_delay_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (dly_q >= DLY_W'(MIN_DLY)));

endmodule

bind recov_seq recov_seq_chk #(
  .DLY_W(DLY_W), .PULSES(PULSES), .MIN_DLY(MIN_DLY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .busy(busy), .done(done),
  .sda_oe(sda_oe), .scl_oe(scl_oe), .iter_idx(iter_idx), .dly_q(dly_q)
);

// File: tb/test_recov_seq.sv
`timescale 1ns/1ps
module test_recov_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        tick_us = 1'b0;
  logic [15:0] delay_us = 16'd0;
  logic        scl_oe, sda_oe, busy, done;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  int tick_per = 1;
  int tick_cnt = 0;

  // reference model state
  bit m_run = 0;
  bit m_done = 0;
  int m_pos = 0;
  int m_d = 2;

  always #10 clk = ~clk;

  recov_seq i_recov_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .tick_us(tick_us),
    .delay_us(delay_us), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .busy(busy), .done(done)
  );

  // Reference model: position in ticks since start of the train
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_done = 0; m_pos = 0; m_d = 2;
    end else begin
      m_done = 0;
      if (!m_run) begin
        if (req) begin
          m_run = 1; m_pos = 0;
          m_d = (int'(delay_us) < 2) ? 2 : int'(delay_us);
        end
      end else if (tick_us) begin
        if (m_pos == 27 * m_d - 1) begin
          m_run = 0; m_done = 1;
        end else m_pos++;
      end
    end
  end

  // Tick generator
  always @(negedge clk) begin
    if (tick_per == 0) tick_us <= 1'b0;
    else begin
      tick_cnt++;
      tick_us <= (tick_cnt % tick_per) == 0;
    end
  end

  // Compare every cycle away from the active edge
  always @(negedge clk) begin
    bit e_sda, e_scl;
    int w;
    e_sda = 0; e_scl = 0;
    if (m_run) begin
      w = m_pos % (3 * m_d);
      if (w < m_d) begin e_sda = 1; e_scl = (w != 0); end
      else begin e_sda = (w == m_d); e_scl = 0; end
    end
    vectors++;
    if (busy !== m_run) begin
      errors++; $display("FAIL R2 busy act=%b exp=%b t=%0t", busy, m_run, $time);
    end
    if (done !== m_done) begin
      errors++; $display("FAIL R3 done act=%b exp=%b t=%0t", done, m_done, $time);
    end
    if (sda_oe !== e_sda || scl_oe !== e_scl) begin
      errors++;
      if (!m_run)
        $display("FAIL R9 sda/scl act=%b%b exp=%b%b t=%0t", sda_oe, scl_oe, e_sda, e_scl, $time);
      else if ((m_pos % (3 * m_d)) < m_d)
        $display("FAIL R4 sda/scl act=%b%b exp=%b%b t=%0t", sda_oe, scl_oe, e_sda, e_scl, $time);
      else
        $display("FAIL R5 sda/scl act=%b%b exp=%b%b t=%0t", sda_oe, scl_oe, e_sda, e_scl, $time);
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp<150000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic start_seq(input logic [15:0] d);
    @(negedge clk);
    delay_us = d; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_end();
    while (m_run) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    // R1: reset state checked by the per-cycle compare (model all zero)
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3 R4 R5: D=3, tick every cycle
    tick_per = 1;
    start_seq(16'd3); wait_end();

    // R6: values below the floor act as 2
    tick_per = 3;
    start_seq(16'd0); wait_end();
    start_seq(16'd1); wait_end();
    start_seq(16'd2); wait_end();

    // R7 R8: delay change and repeated requests during a train
    tick_per = 2;
    start_seq(16'd4);
    repeat (30) begin
      @(negedge clk); req = 1'b1; delay_us = 16'd9;
    end
    @(negedge clk); req = 1'b0; delay_us = 16'd1;
    // R10: no ticks for a while in mid-train
    tick_per = 0;
    repeat (40) @(negedge clk);
    tick_per = 2;
    wait_end();

    // R2: back-to-back start right after done (request held high)
    tick_per = 1;
    @(negedge clk); delay_us = 16'd2; req = 1'b1;
    while (!m_done) @(negedge clk);
    @(negedge clk); req = 1'b0;
    wait_end();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule